// File: doc/BRIEF.md
# Cartridge Disk Controller Register Interface

This block is the controller-side register file and command sequencer of a multi-drive cartridge disk subsystem. A host reaches it through a byte-wide programmed-I/O port with five one-cycle strobes: drive select, data read, data write, status sense and command output. It keeps the function code, the status byte, a one-byte data buffer, the head/sector address, the saved drive number and the platter bit. It decides whether a command is taken and starts legal functions. While idle it reports the rotational sector under the heads. It finishes a transfer by going idle, pulsing the controller interrupt and, on error, pulsing a stop to the DMA channel.

Seek mechanics and sector address checks live in neighbouring blocks. This block sees them only as a per-drive busy vector and a completion strobe that carries error flags. The data read and data write ports change meaning with the idle bit. While idle they return the rotating sector number or load the head/sector address. While a transfer is open they move the data buffer byte and mark the controller busy.

Top module: `disk_ctrl_regs`

## Requirements
- R1: After `rst`, and after a command byte with bit 3 set, the sensed status is 0x0A (busy and idle). The function code, saved drive, platter, head/sector and data buffer all read as zero. The clear command also pulses `drive_reset` for one cycle and leaves the sector counter running.
- R2: The status byte has overrun at bit 7, compare fail at bit 6, defective track at bit 5, cylinder overflow at bit 4, busy at bit 3, idle at bit 1 and transfer error at bit 0. A sense returns this byte in `dout` one cycle later. Bit 2 is set in the sensed byte exactly when any of bits 7..4 is set.
- R3: The sector counter starts at 0, advances by one on each `sector_tick` and wraps from 23 to 0. A data read while idle returns that count and leaves the status unchanged.
- R4: A data read while not idle returns the data buffer byte and sets the busy bit.
- R5: A data write while idle loads `din[5:0]` into the head/sector register. A data write while not idle stores `din` in the data buffer, sets busy and leaves the head/sector register unchanged.
- R6: A non-clear command is ignored (function code, platter and status unchanged, no start) when the controller is not idle or when the saved drive's `drive_busy` bit is set.
- R7: An accepted command with function code 2 (write) clears the status byte to 0x00. Any other accepted code sets the status to 0x08.
- R8: An accepted command stores `din[3:0]` as the function code. `start_op` pulses one cycle later only for codes 1 (read), 2 (write) and 3 (read check).
- R9: A completion strobe sets idle, ORs in `done_flags & 0xF1` and clears busy. It pulses `ctrl_irq` one cycle later, and pulses `dma_stop` in the same cycle exactly when the masked flags are nonzero.
- R10: A select strobe saves the drive number and upper-platter bit only while idle. The platter bit goes to `platter` when the next command is accepted.
- R11: When a completion strobe arrives in the same cycle as a host strobe, the host access acts on the state before completion, and completion is applied on top of it. A clear command in the same cycle as completion wins: no interrupt, and the status is 0x0A.

Verification of the same-cycle rule in R11 uses its own directed cases after the main checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sector_tick | input | 1 | One pulse per sector time |
| sel_stb | input | 1 | Drive select strobe |
| sel_unit | input | UW | Drive number for select |
| sel_upper | input | 1 | Upper-platter bit for select |
| rd_stb | input | 1 | Data read strobe |
| wr_stb | input | 1 | Data write strobe |
| sense_stb | input | 1 | Status sense strobe |
| cmd_stb | input | 1 | Command output strobe |
| din | input | 8 | Host write byte |
| drive_busy | input | NDRV | Per-drive busy (seek in progress) |
| done_stb | input | 1 | Transfer completion strobe |
| done_flags | input | 8 | Error flags delivered with completion |
| dout | output | 8 | Registered read/sense result |
| op_code | output | 4 | Stored function code |
| start_op | output | 1 | Pulse: legal function started |
| cur_unit | output | UW | Saved drive number |
| platter | output | 1 | Platter of the current operation |
| head_sector | output | 6 | Head/sector register |
| ctrl_irq | output | 1 | Controller interrupt pulse |
| dma_stop | output | 1 | DMA channel stop pulse |
| drive_reset | output | 1 | Drive reset pulse on clear command |

## Verification
Completion can fall in the same cycle as a host data read, or as a clear command. The bench opens a read transfer, writes a known buffer byte, and then fires a data read and a completion with a compare-fail flag on the same edge. It expects the buffer byte on `dout`, and then a sensed status of idle plus compare fail plus exception with busy clear. It also fires a clear and a completion together, and expects status 0x0A, no interrupt and a `drive_reset` pulse.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int BIT_OVR  = 7;
  localparam int BIT_ACF  = 6;
  localparam int BIT_DEF  = 5;
  localparam int BIT_CYO  = 4;
  localparam int BIT_BUSY = 3;
  localparam int BIT_EXC  = 2;
  localparam int BIT_IDLE = 1;
  localparam int BIT_DTE  = 0;
  localparam logic [7:0] ERR_MASK  = 8'hF1;
  localparam logic [7:0] EXC_SRC   = 8'hF0;
  localparam logic [7:0] ST_RESET  = 8'h0A;
  localparam logic [7:0] ST_BUSY   = 8'h08;
  localparam logic [3:0] FN_READ   = 4'd1;
  localparam logic [3:0] FN_WRITE  = 4'd2;
  localparam logic [3:0] FN_RCHK   = 4'd3;
endpackage

// File: rtl/dkc_sector_ctr.sv
module dkc_sector_ctr #(
  parameter int NSEC = 24,
  localparam int SW = $clog2(NSEC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [SW-1:0] sec
);
  always_ff @(posedge clk) begin
    if (rst) sec <= '0;
    else if (tick) sec <= (sec == SW'(NSEC - 1)) ? '0 : sec + 1'b1;
  end

  AST_SECTOR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    sec <= SW'(NSEC - 1)); // R3
endmodule

// File: rtl/dkc_cmd_decode.sv
module dkc_cmd_decode #(
  parameter int NDRV = 4,
  localparam int UW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic            cmd_stb,
  input  logic [3:0]      code,
  input  logic            idle,
  input  logic [NDRV-1:0] drive_busy,
  input  logic [UW-1:0]   unit,
  output logic            do_clear,
  output logic            accept,
  output logic            legal
);
  import dkc_pkg::*;
  always_comb begin
    do_clear = cmd_stb & code[3];
    accept   = cmd_stb & ~code[3] & idle & ~drive_busy[unit];
    legal    = (code == FN_READ) | (code == FN_WRITE) | (code == FN_RCHK);
  end
endmodule

// File: rtl/dkc_readout.sv
module dkc_readout #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_stb,
  input  logic          sense_stb,
  input  logic          idle,
  input  logic [SW-1:0] sec,
  input  logic [7:0]    dbuf,
  input  logic [7:0]    status,
  output logic [7:0]    dout
);
  import dkc_pkg::*;
  logic [7:0] sensed;
  always_comb begin
    sensed = status;
    sensed[BIT_EXC] = |(status & EXC_SRC);
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (sense_stb) dout <= sensed;
    else if (rd_stb) dout <= idle ? 8'(sec) : dbuf;
  end

  AST_SENSE_EXC: assert property (@(posedge clk) disable iff (rst)
    sense_stb |=> (dout[BIT_EXC] == |(dout & EXC_SRC))); // R2
endmodule

// File: rtl/disk_ctrl_regs.sv
module disk_ctrl_regs #(
  parameter int NDRV = 4,
  parameter int NSEC = 24,
  localparam int UW = (NDRV > 1) ? $clog2(NDRV) : 1,
  localparam int SW = $clog2(NSEC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sector_tick,
  input  logic            sel_stb,
  input  logic [UW-1:0]   sel_unit,
  input  logic            sel_upper,
  input  logic            rd_stb,
  input  logic            wr_stb,
  input  logic            sense_stb,
  input  logic            cmd_stb,
  input  logic [7:0]      din,
  input  logic [NDRV-1:0] drive_busy,
  input  logic            done_stb,
  input  logic [7:0]      done_flags,
  output logic [7:0]      dout,
  output logic [3:0]      op_code,
  output logic            start_op,
  output logic [UW-1:0]   cur_unit,
  output logic            platter,
  output logic [5:0]      head_sector,
  output logic            ctrl_irq,
  output logic            dma_stop,
  output logic            drive_reset
);
  import dkc_pkg::*;

  logic [7:0]    status, st_n;
  logic [7:0]    dbuf;
  logic          upper_sel;
  logic [SW-1:0] sec;
  logic          idle, do_clear, accept, legal;
  logic [7:0]    err_in;

  assign idle   = status[BIT_IDLE];
  assign err_in = done_flags & ERR_MASK;

  dkc_sector_ctr #(.NSEC(NSEC)) u_sec (
    .clk(clk), .rst(rst), .tick(sector_tick), .sec(sec));

  dkc_cmd_decode #(.NDRV(NDRV)) u_dec (
    .cmd_stb(cmd_stb), .code(din[3:0]), .idle(idle), .drive_busy(drive_busy),
    .unit(cur_unit), .do_clear(do_clear), .accept(accept), .legal(legal));

  dkc_readout #(.SW(SW)) u_out (
    .clk(clk), .rst(rst || do_clear), .rd_stb(rd_stb), .sense_stb(sense_stb),
    .idle(idle), .sec(sec), .dbuf(dbuf), .status(status), .dout(dout));

  // host effect first, completion layered on top
  always_comb begin
    st_n = status;
    if ((rd_stb || wr_stb) && !idle) st_n[BIT_BUSY] = 1'b1;
    if (accept) st_n = (din[3:0] == FN_WRITE) ? 8'h00 : ST_BUSY;
    if (done_stb) begin
      st_n = st_n | err_in;
      st_n[BIT_IDLE] = 1'b1;
      st_n[BIT_BUSY] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || do_clear) begin
      status      <= ST_RESET;
      op_code     <= '0;
      dbuf        <= '0;
      cur_unit    <= '0;
      upper_sel   <= 1'b0;
      platter     <= 1'b0;
      head_sector <= '0;
      start_op    <= 1'b0;
      ctrl_irq    <= 1'b0;
      dma_stop    <= 1'b0;
      drive_reset <= do_clear && !rst;
    end else begin
      status      <= st_n;
      drive_reset <= 1'b0;
      if (sel_stb && idle) begin
        cur_unit  <= sel_unit;
        upper_sel <= sel_upper;
      end
      if (wr_stb) begin
        if (idle) head_sector <= din[5:0];
        else      dbuf        <= din;
      end
      if (accept) begin
        op_code <= din[3:0];
        platter <= upper_sel;
      end
      start_op <= accept && legal;
      ctrl_irq <= done_stb;
      dma_stop <= done_stb && (err_in != 8'h00);
    end
  end

  AST_DMA_STOP_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    dma_stop |-> ctrl_irq); // R9
  AST_START_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    start_op |-> (op_code >= FN_READ && op_code <= FN_RCHK)); // R8
  AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
    (start_op && !$past(done_stb)) |-> !status[BIT_IDLE]); // R7
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && din[3]) |=> (status == ST_RESET && op_code == 4'd0 && !ctrl_irq)); // R1
  AST_IGNORE_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && !din[3] && !status[BIT_IDLE]) |=> ($stable(op_code) && !start_op)); // R6
  AST_COMPLETE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (done_stb && !(cmd_stb && din[3])) |=> (status[BIT_IDLE] && !status[BIT_BUSY])); // R9
endmodule

// File: tb/tb_disk_ctrl_regs.sv
`timescale 1ns/1ps
module tb_disk_ctrl_regs;
  localparam int NDRV = 4;
  localparam int UW = 2;
  localparam int NSEC = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sector_tick = 0, sel_stb = 0, sel_upper = 0, rd_stb = 0, wr_stb = 0;
  logic sense_stb = 0, cmd_stb = 0, done_stb = 0;
  logic [UW-1:0] sel_unit = '0;
  logic [7:0] din = '0, done_flags = '0;
  logic [NDRV-1:0] drive_busy = '0;
  logic [7:0] dout;
  logic [3:0] op_code;
  logic start_op, platter, ctrl_irq, dma_stop, drive_reset;
  logic [UW-1:0] cur_unit;
  logic [5:0] head_sector;

  int vectors = 0;
  int fails = 0;
  int sc = 0;
  logic [7:0] prev;

  always #2.5 clk = ~clk;

  disk_ctrl_regs #(.NDRV(NDRV), .NSEC(NSEC)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sensed(input logic [7:0] s);
    return s | (((s & 8'hF0) != 0) ? 8'h04 : 8'h00);
  endfunction

  task automatic step();
    @(negedge clk);
    sector_tick = 0; sel_stb = 0; rd_stb = 0; wr_stb = 0;
    sense_stb = 0; cmd_stb = 0; done_stb = 0;
  endtask
  task automatic t_sense();  sense_stb = 1; step(); endtask
  task automatic t_rd();     rd_stb = 1; step(); endtask
  task automatic t_wr(input logic [7:0] d); wr_stb = 1; din = d; step(); endtask
  task automatic t_cmd(input logic [7:0] d); cmd_stb = 1; din = d; step(); endtask
  task automatic t_sel(input logic [UW-1:0] u, input logic up);
    sel_stb = 1; sel_unit = u; sel_upper = up; step();
  endtask
  task automatic t_done(input logic [7:0] f); done_stb = 1; done_flags = f; step(); endtask
  task automatic t_tick(); sector_tick = 1; step(); sc = (sc + 1) % NSEC; endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 op_code", op_code, 0);
    chk("R1 head_sector", head_sector, 0);
    chk("R1 cur_unit", cur_unit, 0);
    chk("R1 platter", platter, 0);
    chk("R1 irq", ctrl_irq, 0);
    t_sense(); chk("R1/R2 status", dout, 8'h0A);

    // R3 sector sweep while idle
    for (int i = 0; i < 60; i++) begin
      t_rd(); chk("R3 sector", dout, sc);
      t_tick();
    end
    t_sense(); chk("R3 status unchanged", dout, 8'h0A);

    // R5 idle write loads head/sector
    for (int v = 0; v < 256; v++) begin
      t_wr(8'(v)); chk("R5 head_sector", head_sector, v & 63);
    end

    // R7 R8 R10 command sweep from idle
    for (int f = 0; f < 8; f++) begin
      t_sel(UW'(f % 4), f[0]);
      chk("R10 cur_unit", cur_unit, f % 4);
      t_cmd(8'(f));
      chk("R8 start_op", start_op, (f >= 1 && f <= 3));
      chk("R8 op_code", op_code, f);
      chk("R10 platter", platter, f & 1);
      t_sense(); chk("R7 status", dout, (f == 2) ? 8'h00 : 8'h08);
      t_done(8'h00);
      chk("R9 irq", ctrl_irq, 1);
      chk("R9 dma_stop clean", dma_stop, 0);
      t_sense(); chk("R9 status idle", dout, 8'h02);
    end

    // R4 R5 R6 R10 while not idle
    t_sel(2'd1, 1'b0);
    t_cmd(8'h02);
    t_wr(8'hA5);
    chk("R5 head_sector kept", head_sector, 6'h3F);
    t_sense(); chk("R5 busy set by write", dout, 8'h08);
    t_rd(); chk("R4 buffer read", dout, 8'hA5);
    t_sel(2'd3, 1'b1); chk("R10 select ignored", cur_unit, 1);
    t_cmd(8'h01);
    chk("R6 op_code kept", op_code, 2);
    chk("R6 no start", start_op, 0);

    // R4 read sets busy from status 0
    t_done(8'h00);
    t_cmd(8'h02);
    t_rd(); chk("R4 buffer again", dout, 8'hA5);
    t_sense(); chk("R4 busy set by read", dout, 8'h08);
    t_done(8'h00);

    // R9 R2 error-flag sweep
    for (int e = 0; e < 256; e++) begin
      t_cmd(8'h01);
      t_done(8'(e));
      chk("R9 irq", ctrl_irq, 1);
      chk("R9 dma_stop", dma_stop, (e & 8'hF1) != 0);
      t_sense(); chk("R2 sensed status", dout, sensed(8'h02 | (8'(e) & 8'hF1)));
    end

    // R6 drive busy
    t_sel(2'd2, 1'b0);
    drive_busy = 4'b0100;
    t_cmd(8'h03);
    chk("R6 busy drive no start", start_op, 0);
    chk("R6 busy drive op_code", op_code, 1);
    t_sense(); prev = dout; chk("R6 still idle", prev[1], 1);
    drive_busy = 4'b1011;
    t_cmd(8'h03);
    chk("R6 other drive busy start", start_op, 1);
    chk("R6 op_code 3", op_code, 3);
    drive_busy = '0;

    // R11 same-cycle read + completion
    t_wr(8'h3C);
    rd_stb = 1; done_stb = 1; done_flags = 8'h40; step();
    chk("R11 read sees buffer", dout, 8'h3C);
    chk("R11 irq", ctrl_irq, 1);
    t_sense(); chk("R11 status after", dout, 8'h46);

    // R11 R1 clear with completion
    t_wr(8'h15);
    chk("R1 head_sector set", head_sector, 6'h15);
    t_sel(2'd3, 1'b1);
    t_tick();
    cmd_stb = 1; din = 8'h08; done_stb = 1; done_flags = 8'h01; step();
    chk("R11 no irq on clear", ctrl_irq, 0);
    chk("R11 no dma_stop", dma_stop, 0);
    chk("R1 drive_reset", drive_reset, 1);
    chk("R1 head_sector clr", head_sector, 0);
    chk("R1 cur_unit clr", cur_unit, 0);
    chk("R1 op_code clr", op_code, 0);
    t_sense(); chk("R1 clear status", dout, 8'h0A);
    chk("R1 drive_reset pulse", drive_reset, 0);
    t_rd(); chk("R1 sector keeps running", dout, sc);
    t_cmd(8'h02);
    t_rd(); chk("R1 buffer cleared", dout, 8'h00);
    chk("R1 platter clr", platter, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule